// File: doc/BRIEF.md
# Ethernet Frame Statistics Counters with Half-Range Interrupts

This block keeps five frame statistics counters for an Ethernet MAC. Two of them count receive-side error frames: frames with a CRC error and frames with an alignment error. The other three count transmit-side good frames in three groups: all good frames, good frames sent after exactly one collision, and good frames sent after more than one collision. The MAC drives a single-cycle event pulse for each frame outcome, and the matching counter advances by one.

Each counter owns a sticky status bit. The bit sets when the counter reaches half of its range, which is the moment its most significant bit turns from 0 to 1. Software reads the status through one transmit and one receive status word. To clear a bit, software reads the counter behind it, and that read must include the lowest byte lane. Reading a status word never clears it. The five status bits are ORed into one registered interrupt line.

All registers are read-only and sit on a simple read port with byte-lane enables. Read data is registered and appears one cycle after the request.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter, every status bit, the interrupt output and the read data are zero.
- R2: Each event pulse held high for one cycle adds exactly one to its own counter. The counters are mapped at these offsets: single-collision good 0x14C, multi-collision good 0x150, good 0x154, CRC error 0x158, alignment error 0x15C. Each is zero-extended to 32 bits when read.
- R3: The transmit status word at 0x108 carries the good-frame bit at position 21, the multi-collision bit at 14+1=15, and the single-collision bit at 14. The receive status word at 0x104 carries the alignment bit at 6 and the CRC bit at 5. Every other bit reads as zero.
- R4: A status bit sets in the same cycle that its counter's most significant bit changes from 0 to 1.
- R5: A read of either status word leaves all status bits unchanged. A counter read with byte enable bit 0 set clears that counter's status bit.
- R6: A counter read whose byte enables leave bit 0 clear does not clear the status bit. Bytes whose enable is clear read as zero.
- R7: If a counter's most significant bit first turns to 1 in the same cycle as a clearing read of that counter, the status bit ends as 1.
- R8: A counter wraps from all ones to zero, and the wrap does not set its status bit.
- R9: A read returns the counter value from before any increment in the same cycle. That increment still takes effect.
- R10: The interrupt output is the OR of the five status bits, delayed by one register stage.
- R11: Read data appears in the cycle after the read request. Without a request the read data is zero. Unmapped or misaligned addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_tx_good | input | 1 | Pulse: a good frame was transmitted |
| ev_tx_1col | input | 1 | Pulse: a good frame was transmitted after exactly one collision |
| ev_tx_mcol | input | 1 | Pulse: a good frame was transmitted after more than one collision |
| ev_rx_crc | input | 1 | Pulse: a frame with a CRC error was received |
| ev_rx_align | input | 1 | Pulse: a frame with an alignment error was received |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte offset of the register to read |
| rd_be | input | 4 | Byte-lane enables of the read |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the block with CNT_W=8 and leaves ADDR_W at 12. With this width the half-range point is 128 events and the wrap is at 256. The bench can therefore reach the status-set edge, the collision between a set and a clearing read, and the silent wrap with a few hundred pulses each. With the 32-bit default, the same points would need billions of events.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
    localparam int NUM_CNT = 5;

    // counter slots (also the order of the counter words in the map)
    localparam int IDX_TX_1COL  = 0;
    localparam int IDX_TX_MCOL  = 1;
    localparam int IDX_TX_GOOD  = 2;
    localparam int IDX_RX_CRC   = 3;
    localparam int IDX_RX_ALIGN = 4;

    // byte offsets
    localparam int unsigned RX_STS_OFS   = 32'h104;
    localparam int unsigned TX_STS_OFS   = 32'h108;
    localparam int unsigned CNT_BASE_OFS = 32'h14C;

    // status bit positions inside the status words
    localparam int TX_GOOD_BIT  = 21;
    localparam int TX_MCOL_BIT  = 15;
    localparam int TX_1COL_BIT  = 14;
    localparam int RX_ALIGN_BIT = 6;
    localparam int RX_CRC_BIT   = 5;
endpackage

// File: rtl/mac_stat_counter.sv
module mac_stat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sts_o
);
    localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sts;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    hit_half;

    always_comb begin
        s_d      = s_q;
        hit_half = inc_i && (s_q.cnt == HALF_M1);
        if (inc_i) begin
            s_d.cnt = s_q.cnt + ONE;
        end
        if (hit_half) begin
            s_d.sts = 1'b1;
        end else if (clr_i) begin
            s_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign sts_o = s_q.sts;

    // R4: a status bit only rises together with the counter MSB
    a_r4_set_with_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sts) |-> $rose(s_q.cnt[CNT_W-1]));

    // R7: when the MSB turns on, the status bit is 1 whatever the read did
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.cnt[CNT_W-1]) |-> s_q.sts);

    // R8: a wrap never raises the status bit
    a_r8_wrap_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.cnt[CNT_W-1]) |-> !$rose(s_q.sts));

    // R9: no event, no change
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(s_q.cnt));
endmodule

// File: rtl/mac_stat_regs.sv
module mac_stat_regs
    import mac_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    input  logic [3:0]               rd_be_i,
    input  logic [NUM_CNT*CNT_W-1:0] cnt_i,
    input  logic [NUM_CNT-1:0]       sts_i,
    output logic [NUM_CNT-1:0]       clr_o,
    output logic [31:0]              rd_data_o
);
    typedef struct packed {
        logic [31:0] rdata;
    } rd_st_t;

    rd_st_t             r_d, r_q;
    logic [NUM_CNT-1:0] sel;
    logic [31:0]        tx_word, rx_word, word, lane_mask;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
        assign sel[i] = (rd_addr_i == ADDR_W'(CNT_BASE_OFS + 4 * i));
    end

    assign clr_o = sel & {NUM_CNT{rd_en_i & rd_be_i[0]}};

    always_comb begin
        tx_word = '0;
        rx_word = '0;
        tx_word[TX_GOOD_BIT]  = sts_i[IDX_TX_GOOD];
        tx_word[TX_MCOL_BIT]  = sts_i[IDX_TX_MCOL];
        tx_word[TX_1COL_BIT]  = sts_i[IDX_TX_1COL];
        rx_word[RX_ALIGN_BIT] = sts_i[IDX_RX_ALIGN];
        rx_word[RX_CRC_BIT]   = sts_i[IDX_RX_CRC];
    end

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            lane_mask[8*b +: 8] = {8{rd_be_i[b]}};
        end
    end

    always_comb begin
        r_d  = '0;
        word = '0;
        if (rd_addr_i == ADDR_W'(RX_STS_OFS)) begin
            word = rx_word;
        end else if (rd_addr_i == ADDR_W'(TX_STS_OFS)) begin
            word = tx_word;
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel[i]) begin
                word = 32'(cnt_i[i*CNT_W +: CNT_W]);
            end
        end
        if (rd_en_i) begin
            r_d.rdata = word & lane_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data_o = r_q.rdata;

    // R6: no clear without byte lane 0 on a read
    a_r6_clear_needs_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && rd_be_i[0]) |-> (clr_o == '0));

    // R11: idle cycles return zero on the next cycle
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == 32'h0));
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_good,
    input  logic              ev_tx_1col,
    input  logic              ev_tx_mcol,
    input  logic              ev_rx_crc,
    input  logic              ev_rx_align,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [3:0]        rd_be,
    output logic [31:0]       rd_data,
    output logic              irq
);
    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t                  t_d, t_q;
    logic [NUM_CNT-1:0]       inc, clr, sts;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;

    always_comb begin
        inc               = '0;
        inc[IDX_TX_1COL]  = ev_tx_1col;
        inc[IDX_TX_MCOL]  = ev_tx_mcol;
        inc[IDX_TX_GOOD]  = ev_tx_good;
        inc[IDX_RX_CRC]   = ev_rx_crc;
        inc[IDX_RX_ALIGN] = ev_rx_align;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        mac_stat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (inc[i]),
            .clr_i (clr[i]),
            .cnt_o (cnt_flat[i*CNT_W +: CNT_W]),
            .sts_o (sts[i])
        );
    end

    mac_stat_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_be_i   (rd_be),
        .cnt_i     (cnt_flat),
        .sts_i     (sts),
        .clr_o     (clr),
        .rd_data_o (rd_data)
    );

    always_comb begin
        t_d     = t_q;
        t_d.irq = |sts;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign irq = t_q.irq;

    // R10: interrupt follows the status OR one cycle later
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|sts) |=> irq);
    a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !(|sts) |=> !irq);

    // R5: a status-word read changes no status bit
    a_r5_status_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == ADDR_W'(RX_STS_OFS) || rd_addr == ADDR_W'(TX_STS_OFS))
         && !(|inc)) |=> $stable(sts));
endmodule

// File: tb/sim_mac_stat_bank.sv
module sim_mac_stat_bank;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 12;
    localparam logic [11:0] A_RX  = 12'h104, A_TX  = 12'h108;
    localparam logic [11:0] A_1C  = 12'h14C, A_MC  = 12'h150, A_GD = 12'h154;
    localparam logic [11:0] A_CRC = 12'h158, A_AL  = 12'h15C;
    // event mask bits: 0 1col, 1 mcol, 2 good, 3 crc, 4 align
    localparam logic [4:0] M_1C = 5'b00001, M_MC = 5'b00010, M_GD = 5'b00100;
    localparam logic [4:0] M_CRC = 5'b01000, M_AL = 5'b10000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        evs = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [3:0]        rd_be = '0;
    logic [31:0]       rd_data;
    logic              irq;
    int                errors = 0;
    int                checks = 0;
    bit                done = 1'b0;
    logic [31:0]       v;

    always #4 clk = ~clk;

    mac_stat_bank #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_good(evs[2]), .ev_tx_1col(evs[0]), .ev_tx_mcol(evs[1]),
        .ev_rx_crc(evs[3]), .ev_rx_align(evs[4]),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_be(rd_be),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] m, input int n);
        @(negedge clk);
        evs = m;
        repeat (n) @(negedge clk);
        evs = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; rd_be = be;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rd_data", rd_data, 0);
        rd(A_TX, 4'hF, v);  chk("R1 tx status", v, 0);
        rd(A_RX, 4'hF, v);  chk("R1 rx status", v, 0);
        rd(A_CRC, 4'hF, v); chk("R1 crc counter", v, 0);
    endtask

    task automatic t_count;
        pulse(M_1C, 3);
        pulse(M_MC, 5);
        pulse(M_GD, 7);
        pulse(M_1C | M_MC | M_GD, 2);
        rd(A_1C, 4'hF, v); chk("R2 1col count", v, 5);
        rd(A_MC, 4'hF, v); chk("R2 mcol count", v, 7);
        rd(A_GD, 4'hF, v); chk("R2 good count", v, 9);
        rd(A_AL, 4'hF, v); chk("R2 align untouched", v, 0);
        @(negedge clk);    chk("R11 idle read data", rd_data, 0);
        rd(12'h110, 4'hF, v); chk("R11 unmapped", v, 0);
        rd(12'h14E, 4'hF, v); chk("R11 misaligned", v, 0);
    endtask

    task automatic t_half_crc;
        pulse(M_CRC, 127);
        rd(A_RX, 4'hF, v); chk("R4 below half", v, 0);
        pulse(M_CRC, 1);
        chk("R10 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R10 irq raised", {31'b0, irq}, 1);
        rd(A_RX, 4'hF, v); chk("R4 R3 crc status bit5", v, 32'h20);
        rd(A_RX, 4'hF, v); chk("R5 status read keeps", v, 32'h20);
        rd(A_CRC, 4'hE, v); chk("R6 lane0 masked", v, 0);
        rd(A_RX, 4'hF, v); chk("R6 upper lanes keep status", v, 32'h20);
        rd(A_CRC, 4'h1, v); chk("R6 lane0 data", v, 32'h80);
        chk("R10 irq lags clear", {31'b0, irq}, 1);
        @(negedge clk);
        chk("R10 irq dropped", {31'b0, irq}, 0);
        rd(A_RX, 4'hF, v); chk("R5 counter read clears", v, 0);
    endtask

    task automatic t_tx_bits;
        pulse(M_GD, 119);
        rd(A_TX, 4'hF, v); chk("R3 good bit21", v, 32'h0020_0000);
        pulse(M_MC, 121);
        rd(A_TX, 4'hF, v); chk("R3 mcol bit15", v, 32'h0020_8000);
        pulse(M_1C, 123);
        rd(A_TX, 4'hF, v); chk("R3 1col bit14", v, 32'h0020_C000);
        rd(A_RX, 4'hF, v); chk("R3 rx word untouched", v, 0);
        rd(A_GD, 4'hF, v); chk("R2 good at half", v, 128);
        rd(A_MC, 4'h3, v);
        rd(A_1C, 4'h1, v);
        rd(A_TX, 4'hF, v); chk("R5 tx all cleared", v, 0);
    endtask

    task automatic t_collide;
        pulse(M_AL, 127);
        @(negedge clk);
        evs = M_AL; rd_en = 1'b1; rd_addr = A_AL; rd_be = 4'hF;
        @(negedge clk);
        evs = '0; rd_en = 1'b0;
        chk("R9 pre-increment value", rd_data, 127);
        rd(A_RX, 4'hF, v); chk("R7 set wins", v, 32'h40);
        rd(A_AL, 4'hF, v); chk("R9 event kept", v, 128);
        rd(A_RX, 4'hF, v); chk("R5 align cleared", v, 0);
    endtask

    task automatic t_wrap;
        pulse(M_CRC, 127);
        rd(A_CRC, 4'hF, v); chk("R8 at all ones", v, 255);
        pulse(M_CRC, 1);
        rd(A_CRC, 4'hF, v); chk("R8 wrapped", v, 0);
        rd(A_RX, 4'hF, v);  chk("R8 no status on wrap", v, 0);
        chk("R8 no irq on wrap", {31'b0, irq}, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_half_crc();
        t_tx_bits();
        t_collide();
        t_wrap();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end
endmodule